// File: doc/BRIEF.md
# CRC32C Digest Engine

This block computes the 32-bit CRC32C digest of a protocol data unit (PDU) one byte per clock. Bytes arrive on a byte bus with a valid qualifier and two framing strobes that mark the first and last byte. Every byte offered between those strobes is divided, pad bytes included. The last byte is qualified by a mode bit that selects either transmit or receive handling for that PDU.

In transmit mode the engine reports the finished CRC and then plays the digest out as four bytes in wire order. It starts in the cycle after the last PDU byte, so the digest can be appended to the outgoing stream. In receive mode the PDU is fed in with its digest bytes still attached. The engine does not pick the CRC field out of the stream. It divides over everything and compares the raw remainder with the fixed residue that a correct digest always leaves. The result is a registered pass flag.

Bits inside each byte are taken least significant first. The shift register therefore holds the remainder in reflected form. The generator is 0x1EDC6F41 in normal notation, which is 0x82F63B78 when reflected.

Top module: `crc32c_digest_engine`

## Requirements
- R1: While reset is held, and after it until the first accepted last byte, `doneStrobe`, `outValid` and `digestOk` are 0 and `crcValue` is 0.
- R2: Over the nine ASCII bytes "123456789" (0x31 to 0x39), sent with `inSop` on the first and `inEop` on the last, `crcValue` reads 0xE3069283. `doneStrobe` is 1 in the cycle after the last byte is accepted and is 1 for that one cycle only.
- R3: `crcValue` is the complement of the remainder of the message times x^32 divided by the generator 0x1EDC6F41. The low bit of the first byte is the highest-order message coefficient, and each byte is taken low bit first.
- R4: A byte accepted with `inSop` restarts the division from an all-ones remainder, also in the middle of an unfinished PDU. The result covers only the bytes from that byte on.
- R5: Cycles with `inValid` at 0 leave the result unchanged, whatever `inByte`, `inSop`, `inEop` and `inCheck` carry in those cycles.
- R6: When the last byte is accepted with `inCheck` = 0 (transmit), `outValid` is 1 for exactly four cycles, starting in the cycle `doneStrobe` is 1. `outByte` carries `crcValue` bits [7:0], [15:8], [23:16] and [31:24], in that order.
- R7: When the last byte is accepted with `inCheck` = 1 (receive), `digestOk` is set together with `doneStrobe` exactly when the uncomplemented remainder over the whole PDU, digest included, equals 0x1C2D19ED (0xB798B438 in the reflected register). A PDU followed by its correct digest in wire order passes.
- R8: Flipping any single bit of a received PDU plus digest clears `digestOk`.
- R9: `digestOk` is 0 after a transmit-mode PDU. `crcValue` and `digestOk` keep their values until the next accepted last byte.
- R10: The receive verdict equals the result of comparing the CRC of the payload alone with the last four bytes read in wire order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Byte on `inByte` is accepted this cycle |
| inByte | input | 8 | PDU byte |
| inSop | input | 1 | Accepted byte is the first of a PDU |
| inEop | input | 1 | Accepted byte is the last of a PDU |
| inCheck | input | 1 | Sampled with the last byte: 1 receive check, 0 transmit |
| outValid | output | 1 | Digest byte present on `outByte` |
| outByte | output | 8 | Digest byte in wire order |
| doneStrobe | output | 1 | One-cycle pulse after the last byte |
| digestOk | output | 1 | Residue matched on the last receive PDU |
| crcValue | output | 32 | CRC of the last finished PDU |

## Verification
A corrupted remainder bit would not show up while a PDU is streaming. It appears at the first `doneStrobe` after it, either as a wrong `crcValue` and wrong digest bytes or as a cleared `digestOk`. That makes every PDU end an observation point. A wrong seed or a wrong bit order fails even the shortest one-byte PDU. Errors in the emitter show up within the four-cycle digest burst, as a wrong byte order or a burst length other than four.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

  typedef struct packed {
    logic seed;         // restart the division from the preset
    logic absorb;       // fold the input byte into the remainder
    logic capture;      // last byte: latch result registers
    logic checkMode;    // receive check requested on this PDU
    logic loadDigest;   // transmit: load the digest emitter
    logic shiftDigest;  // advance the digest emitter by one byte
  } crcStrobe_t;

endpackage

// File: rtl/crc32c_ctrl.sv
module crc32c_ctrl
  import crc32c_pkg::*;
#(
  parameter int CRC_W  = 32,
  parameter int BYTE_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSop,
  input  logic       inEop,
  input  logic       inCheck,
  output crcStrobe_t strobe,
  output logic       doneStrobe,
  output logic       outValid
);

  localparam int DIGEST_BYTES = CRC_W / BYTE_W;
  localparam int CNT_W        = $clog2(DIGEST_BYTES + 1);

  logic [CNT_W-1:0] emitCnt;
  logic             lastByte;

  assign lastByte = inValid && inEop;

  always_comb begin
    strobe.seed        = inValid && inSop;
    strobe.absorb      = inValid;
    strobe.capture     = lastByte;
    strobe.checkMode   = inCheck;
    strobe.loadDigest  = lastByte && !inCheck;
    strobe.shiftDigest = (emitCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneStrobe <= 1'b0;
      emitCnt    <= '0;
    end else begin
      doneStrobe <= lastByte;
      if (lastByte && !inCheck) begin
        emitCnt <= CNT_W'(DIGEST_BYTES);
      end else if (emitCnt != '0) begin
        emitCnt <= emitCnt - 1'b1;
      end
    end
  end

  assign outValid = (emitCnt != '0);

  // R6: a digest burst only begins together with the end-of-PDU pulse
  a_r6_burst_starts_at_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> doneStrobe);

  // R6: the burst counter never exceeds the digest length
  a_r6_burst_len: assert property (@(posedge clk) disable iff (!rstN)
    emitCnt <= CNT_W'(DIGEST_BYTES));

endmodule

// File: rtl/crc32c_datapath.sv
module crc32c_datapath
  import crc32c_pkg::*;
#(
  parameter int              CRC_W     = 32,
  parameter int              BYTE_W    = 8,
  parameter logic [CRC_W-1:0] POLY_REFL = 32'h82F63B78,
  parameter logic [CRC_W-1:0] PRESET    = 32'hFFFFFFFF,
  parameter logic [CRC_W-1:0] RESIDUE   = 32'hB798B438
) (
  input  logic              clk,
  input  logic              rstN,
  input  crcStrobe_t        strobe,
  input  logic [BYTE_W-1:0] inByte,
  output logic [BYTE_W-1:0] outByte,
  output logic              digestOk,
  output logic [CRC_W-1:0]  crcValue
);

  logic [CRC_W-1:0] remReg;
  logic [CRC_W-1:0] remBase;
  logic [CRC_W-1:0] remNext;
  logic [CRC_W-1:0] digestShift;

  assign remBase = strobe.seed ? PRESET : remReg;

  // One byte per clock: BYTE_W shift-and-reduce steps, low bit first.
  always_comb begin
    logic [CRC_W-1:0] acc;
    acc = remBase ^ {{(CRC_W-BYTE_W){1'b0}}, inByte};
    for (int k = 0; k < BYTE_W; k++) begin
      acc = {1'b0, acc[CRC_W-1:1]} ^ (acc[0] ? POLY_REFL : '0);
    end
    remNext = acc;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg <= PRESET;
    end else if (strobe.absorb) begin
      remReg <= remNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcValue <= '0;
      digestOk <= 1'b0;
    end else if (strobe.capture) begin
      crcValue <= ~remNext;
      digestOk <= strobe.checkMode && (remNext == RESIDUE);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      digestShift <= '0;
    end else if (strobe.loadDigest) begin
      digestShift <= ~remNext;
    end else if (strobe.shiftDigest) begin
      digestShift <= {{BYTE_W{1'b0}}, digestShift[CRC_W-1:BYTE_W]};
    end
  end

  assign outByte = digestShift[BYTE_W-1:0];

  // R9: results hold between PDU ends
  a_r9_value_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(crcValue) && $stable(digestOk)));

  // R9: a transmit-mode end never reports a passed check
  a_r9_tx_never_ok: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !strobe.checkMode) |=> !digestOk);

endmodule

// File: rtl/crc32c_digest_engine.sv
module crc32c_digest_engine
  import crc32c_pkg::*;
#(
  parameter int               CRC_W     = 32,
  parameter int               BYTE_W    = 8,
  parameter logic [CRC_W-1:0] POLY_REFL = 32'h82F63B78,
  parameter logic [CRC_W-1:0] PRESET    = 32'hFFFFFFFF,
  parameter logic [CRC_W-1:0] RESIDUE   = 32'hB798B438
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inByte,
  input  logic              inSop,
  input  logic              inEop,
  input  logic              inCheck,
  output logic              outValid,
  output logic [BYTE_W-1:0] outByte,
  output logic              doneStrobe,
  output logic              digestOk,
  output logic [CRC_W-1:0]  crcValue
);

  crcStrobe_t strobe;

  crc32c_ctrl #(
    .CRC_W (CRC_W),
    .BYTE_W(BYTE_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inSop     (inSop),
    .inEop     (inEop),
    .inCheck   (inCheck),
    .strobe    (strobe),
    .doneStrobe(doneStrobe),
    .outValid  (outValid)
  );

  crc32c_datapath #(
    .CRC_W    (CRC_W),
    .BYTE_W   (BYTE_W),
    .POLY_REFL(POLY_REFL),
    .PRESET   (PRESET),
    .RESIDUE  (RESIDUE)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inByte  (inByte),
    .outByte (outByte),
    .digestOk(digestOk),
    .crcValue(crcValue)
  );

  // R7: a pass verdict only appears together with the end-of-PDU pulse
  a_r7_ok_with_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(digestOk) |-> doneStrobe);

endmodule

// File: tb/tb_crc32c_digest_engine.sv
module tb_crc32c_digest_engine;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [7:0]  inByte;
  logic        inSop;
  logic        inEop;
  logic        inCheck;
  logic        outValid;
  logic [7:0]  outByte;
  logic        doneStrobe;
  logic        digestOk;
  logic [31:0] crcValue;

  int total = 0;
  int bad   = 0;
  logic [7:0]  pdu [0:63];
  logic [31:0] rnd = 32'h1234ABCD;

  always #10 clk = ~clk;

  crc32c_digest_engine dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inByte(inByte),
    .inSop(inSop), .inEop(inEop), .inCheck(inCheck),
    .outValid(outValid), .outByte(outByte), .doneStrobe(doneStrobe),
    .digestOk(digestOk), .crcValue(crcValue)
  );

  function automatic logic [31:0] refCrc(int start, int len);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = start; i < start + len; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fb;
        fb = c[0] ^ pdu[i][b];
        c = c >> 1;
        if (fb) c = c ^ 32'h82F63B78;
      end
    end
    return ~c;
  endfunction

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleInputs();
    inValid = 1'b0; inByte = 8'h00; inSop = 1'b0; inEop = 1'b0; inCheck = 1'b0;
  endtask

  // idle cycle carrying noise on every qualifier-gated input (R5)
  task automatic noiseCycle();
    @(negedge clk);
    inValid = 1'b0; inByte = 8'h5A; inSop = 1'b1; inEop = 1'b1; inCheck = 1'b1;
  endtask

  task automatic driveByte(logic [7:0] b, logic sop, logic eop, logic chk);
    @(negedge clk);
    inValid = 1'b1; inByte = b; inSop = sop; inEop = eop; inCheck = chk;
  endtask

  // sends pdu[start .. start+len-1]; returns at the negedge after the last byte
  task automatic sendPdu(int start, int len, logic chk, int gapEvery, logic withEop);
    for (int i = 0; i < len; i++) begin
      if (gapEvery > 0 && i > 0 && (i % gapEvery) == 0) noiseCycle();
      driveByte(pdu[start+i], i == 0, withEop && (i == len - 1), chk);
    end
    @(negedge clk);
  endtask

  task automatic fillRandom(int len);
    for (int i = 0; i < len; i++) begin
      rnd = {rnd[30:0], 1'b0} ^ (rnd[31] ? 32'h04C11DB7 : 32'h0);
      pdu[i] = rnd[7:0] ^ rnd[23:16];
    end
  endtask

  task automatic txRun(int len, int gapEvery, string req);
    logic [31:0] exp;
    exp = refCrc(0, len);
    sendPdu(0, len, 1'b0, gapEvery, 1'b1);
    idleInputs();
    checkEq({req, " done"}, {31'b0, doneStrobe}, 32'd1);
    checkEq({req, " crc"}, crcValue, exp);
    checkEq("R9 tx ok low", {31'b0, digestOk}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      checkEq("R6 digest valid", {31'b0, outValid}, 32'd1);
      checkEq("R6 digest byte", {24'b0, outByte}, {24'b0, exp[8*k +: 8]});
      @(negedge clk);
      if (k == 0) checkEq("R2 done one cycle", {31'b0, doneStrobe}, 32'd0);
    end
    checkEq("R6 burst end", {31'b0, outValid}, 32'd0);
  endtask

  // pdu[0..plen-1] payload, digest appended in wire order
  task automatic appendDigest(int plen);
    logic [31:0] c;
    c = refCrc(0, plen);
    for (int k = 0; k < 4; k++) pdu[plen+k] = c[8*k +: 8];
  endtask

  task automatic rxRun(int len, logic expOk, string req);
    sendPdu(0, len, 1'b1, 0, 1'b1);
    idleInputs();
    checkEq({req, " done"}, {31'b0, doneStrobe}, 32'd1);
    checkEq({req, " ok"}, {31'b0, digestOk}, {31'b0, expOk});
    checkEq({req, " no burst"}, {31'b0, outValid}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idleInputs();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    checkEq("R1 done", {31'b0, doneStrobe}, 32'd0);
    checkEq("R1 outValid", {31'b0, outValid}, 32'd0);
    checkEq("R1 ok", {31'b0, digestOk}, 32'd0);
    checkEq("R1 crc", crcValue, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkEq("R1 after release", {31'b0, doneStrobe | outValid | digestOk}, 32'd0);

    // R2 known string
    for (int i = 0; i < 9; i++) pdu[i] = 8'h31 + 8'(i);
    checkEq("R2 reference", refCrc(0, 9), 32'hE3069283);
    txRun(9, 0, "R2");

    // R3 / R5 / R6 length sweep with and without noisy idle gaps
    for (int len = 1; len <= 40; len++) begin
      fillRandom(len);
      txRun(len, (len % 2 == 0) ? 3 : 0, (len % 2 == 0) ? "R5" : "R3");
    end

    // R4 restart in the middle of an unfinished PDU
    fillRandom(6);
    sendPdu(0, 6, 1'b0, 0, 1'b0);
    for (int i = 0; i < 9; i++) pdu[i] = 8'h31 + 8'(i);
    txRun(9, 2, "R4");

    // R9 hold: idle and a partial PDU do not move the results
    repeat (5) noiseCycle();
    fillRandom(3);
    sendPdu(0, 3, 1'b1, 0, 1'b0);
    idleInputs();
    @(negedge clk);
    checkEq("R9 crc hold", crcValue, 32'hE3069283);
    checkEq("R9 ok hold", {31'b0, digestOk}, 32'd0);

    // R7 good digests pass
    for (int i = 0; i < 9; i++) pdu[i] = 8'h31 + 8'(i);
    appendDigest(9);
    checkEq("R7 wire byte0", {24'b0, pdu[9]}, 32'h83);
    rxRun(13, 1'b1, "R7");
    fillRandom(20);
    appendDigest(20);
    rxRun(24, 1'b1, "R7");
    repeat (4) noiseCycle();
    idleInputs();
    @(negedge clk);
    checkEq("R9 ok hold rx", {31'b0, digestOk}, 32'd1);

    // R9 a valid frame sent in transmit mode never reports ok
    sendPdu(0, 24, 1'b0, 0, 1'b1);
    idleInputs();
    checkEq("R9 tx frame ok", {31'b0, digestOk}, 32'd0);
    repeat (5) @(negedge clk);

    // R8 / R10 single-bit flips over an 8-byte payload plus digest
    fillRandom(8);
    appendDigest(8);
    for (int pos = 0; pos < 12; pos++) begin
      for (int b = 0; b < 8; b++) begin
        logic [31:0] field;
        logic        expOk;
        pdu[pos][b] = ~pdu[pos][b];
        field = {pdu[11], pdu[10], pdu[9], pdu[8]};
        expOk = (refCrc(0, 8) == field);
        checkEq("R10 flip model", {31'b0, expOk}, 32'd0);
        rxRun(12, expOk, "R8");
        pdu[pos][b] = ~pdu[pos][b];
      end
    end
    // R10 unflipped frame: both methods pass
    checkEq("R10 field compare", refCrc(0, 8), {pdu[11], pdu[10], pdu[9], pdu[8]});
    rxRun(12, 1'b1, "R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule